// File: doc/BRIEF.md
# Burst Memory Pattern Tester

This engine checks an external memory in bursts. A host first fills a 256-word local buffer through a small register bus. It then issues commands that either copy a run of buffer words out to memory or fetch a run of words back and compare each one with the buffer. Each burst starts at a chosen buffer offset, so many memory blocks can be filled and checked from a single host-loaded pattern.

A pass flag records whether every compared word has matched. The flag is sticky. Only a read command that asks for a check reset sets it back to "all good". A long sequence of read bursts can therefore be judged with one status poll at the end.

Toward the memory controller the block issues one request carrying address, length and direction. The data then streams one word per handshake: `mem_wvalid`/`mem_wready` for writes and `mem_rvalid` for reads.

Top module: `burst_pattern_tester`

## Requirements
- R1: After reset the status word (register 0) reads 0x00000002: busy (bit 0) clear, pass (bit 1) set. No memory request is raised.
- R2: Host address bit 8 set selects buffer word `host_addr[7:0]`, which can be written and read back. Register 1 holds the memory word address and reads back what was written. A host read returns data in the cycle after `host_re`.
- R3: Writing register 0 while idle starts a burst. Command bits 7:0 hold length minus one and bits 15:8 hold the starting buffer offset. With bit 16 clear, the block raises one request with `mem_req_write`=1, `mem_req_addr` equal to register 1 and `mem_req_len` equal to length minus one. It holds the request until `mem_req_ready`, then presents successive buffer words on `mem_wdata`.
- R4: With command bit 16 set, the block raises a request with `mem_req_write`=0. Each word accepted on `mem_rvalid` is compared against the next successive buffer word.
- R5: The buffer index wraps modulo 256 when a burst runs past word 255.
- R6: A compare mismatch clears status bit 1. The bit stays clear through later matching bursts.
- R7: Command bit 17 on a read sets status bit 1 before that burst's comparison begins. On a write command, bit 17 has no effect.
- R8: Status bit 0 is set from command acceptance until the last word of the burst is transferred. Command writes while busy are ignored.
- R9: A length field above 31 (a burst longer than 32 words) is clamped to a 32-word burst, and `mem_req_len` reads 31.
- R10: Command bit 18 is forwarded as `mem_req_dual` on read requests. `mem_req_dual` is 0 on write requests.
- R11: A stream word advances only on a handshake. When the stream stalls, `mem_wvalid` stays asserted and the block waits for `mem_rvalid`, without skipping words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 9 | Host word address: bit 8 buffer select, else bits 7:0 register index |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after host_re |
| mem_req | output | 1 | Burst request toward the memory controller |
| mem_req_write | output | 1 | 1 = write burst, 0 = read burst |
| mem_req_dual | output | 1 | Dual-mode read requested |
| mem_req_addr | output | 32 | Memory word address of the burst |
| mem_req_len | output | 8 | Burst length minus one |
| mem_req_ready | input | 1 | Controller accepts the request |
| mem_wvalid | output | 1 | Write word valid |
| mem_wdata | output | 32 | Write word |
| mem_wready | input | 1 | Controller takes the write word |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |

## Verification
A wrong buffer pointer shows up immediately on `mem_wdata`, with the wrong word on the very next write handshake. On reads it surfaces only as a cleared pass bit at the next status poll. For that reason the bench checks every streamed write word and uses single-word corruptions on reads. A wrong beat counter ends a burst early or late: the bench sees `mem_wvalid` drop too soon, or busy still set after the expected last word. A stuck pass flag is visible only at a status read, so the bench polls after each burst and across sequences designed to test stickiness.

// File: rtl/burst_pattern_tester.sv
module burst_pattern_tester #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int BUF_AW    = 8,
  parameter int MAX_BURST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUF_AW:0]   host_addr,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_req,
  output logic              mem_req_write,
  output logic              mem_req_dual,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [7:0]        mem_req_len,
  input  logic              mem_req_ready,
  output logic              mem_wvalid,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_wready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int DEPTH = 1 << BUF_AW;
  localparam int CNT_W = $clog2(MAX_BURST);
  localparam logic [7:0] LEN_CAP = 8'(MAX_BURST - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA} st_t;

  st_t               st;
  logic [DATA_W-1:0] buf_q [DEPTH];
  logic [BUF_AW-1:0] ptr;
  logic [CNT_W-1:0]  left;
  logic              is_rd, dual_q, pass;
  logic [ADDR_W-1:0] addr_q, burst_addr;
  logic [7:0]        len_q;

  wire sel_buf = host_addr[BUF_AW];
  wire sel_cmd = !sel_buf && host_addr[BUF_AW-1:0] == '0;
  wire sel_adr = !sel_buf && host_addr[BUF_AW-1:0] == BUF_AW'(1);
  wire cmd_go  = host_we && sel_cmd && st == S_IDLE;
  wire [7:0] len_in = (host_wdata[7:0] > LEN_CAP) ? LEN_CAP : host_wdata[7:0];
  wire beat    = st == S_DATA && (is_rd ? mem_rvalid : mem_wready);
  wire busy    = st != S_IDLE;

  assign mem_req       = st == S_REQ;
  assign mem_req_write = !is_rd;
  assign mem_req_dual  = is_rd && dual_q;
  assign mem_req_addr  = burst_addr;
  assign mem_req_len   = len_q;
  assign mem_wvalid    = st == S_DATA && !is_rd;
  assign mem_wdata     = buf_q[ptr];

  always_ff @(posedge clk)
    if (host_we && sel_buf) buf_q[host_addr[BUF_AW-1:0]] <= host_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) addr_q <= '0;
    else if (host_we && sel_adr) addr_q <= host_wdata[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) host_rdata <= '0;
    else if (host_re) begin
      if (sel_buf)      host_rdata <= buf_q[host_addr[BUF_AW-1:0]];
      else if (sel_adr) host_rdata <= DATA_W'(addr_q);
      else              host_rdata <= DATA_W'({pass, busy});
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st         <= S_IDLE;
      ptr        <= '0;
      left       <= '0;
      is_rd      <= 1'b0;
      dual_q     <= 1'b0;
      len_q      <= '0;
      burst_addr <= '0;
      pass       <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (cmd_go) begin
          st         <= S_REQ;
          ptr        <= host_wdata[15:8];
          left       <= len_in[CNT_W-1:0];
          len_q      <= len_in;
          is_rd      <= host_wdata[16];
          dual_q     <= host_wdata[18];
          burst_addr <= addr_q;
          if (host_wdata[16] && host_wdata[17]) pass <= 1'b1;
        end
        S_REQ: if (mem_req_ready) st <= S_DATA;
        default: if (beat) begin
          ptr <= ptr + 1'b1;
          if (is_rd && mem_rdata != buf_q[ptr]) pass <= 1'b0;
          if (left == '0) st <= S_IDLE;
          else left <= left - 1'b1;
        end
      endcase
    end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_req_ready |=> mem_req && $stable(mem_req_addr) && $stable(mem_req_len));
  p_len_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_req_len <= LEN_CAP);
  p_dual_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_req_write |-> !mem_req_dual);
  p_wvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid);
  p_pass_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(cmd_go && host_wdata[16] && host_wdata[17]));
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && host_we && sel_cmd |=> $stable(mem_req_len) && $stable(mem_req_write));

endmodule

// File: tb/tb_burst_pattern_tester.sv
module tb_burst_pattern_tester;
  logic        clk = 0, rst_n = 0;
  logic [8:0]  host_addr = 0;
  logic        host_we = 0, host_re = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        mem_req, mem_req_write, mem_req_dual, mem_req_ready = 0;
  logic [31:0] mem_req_addr;
  logic [7:0]  mem_req_len;
  logic        mem_wvalid, mem_wready = 0, mem_rvalid = 0;
  logic [31:0] mem_wdata, mem_rdata = 0;
  logic [31:0] buf_model [256];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  burst_pattern_tester dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk); host_we = 0;
  endtask

  task automatic host_rd(input logic [8:0] a, output logic [31:0] d);
    host_addr = a; host_re = 1;
    @(negedge clk); d = host_rdata; host_re = 0;
  endtask

  function automatic logic [31:0] cmd(input bit rd, input bit clr, input bit dual,
                                      input logic [7:0] off, input logic [7:0] lm1);
    return {13'b0, dual, clr, rd, off, lm1};
  endfunction

  task automatic grant(input string tag, input logic [31:0] a, input logic [7:0] lm1,
                       input bit wr, input bit dual);
    for (int t = 0; t < 50 && !mem_req; t++) @(negedge clk);
    chk({tag, " request"}, mem_req, 1);
    chk({tag, " address"}, mem_req_addr, a);
    chk({tag, " length"}, mem_req_len, lm1);
    chk({tag, " direction"}, mem_req_write, wr);
    chk({tag, " R10 dual"}, mem_req_dual, dual);
    mem_req_ready = 1; @(negedge clk); mem_req_ready = 0;
  endtask

  task automatic serve_write(input string tag, input logic [7:0] off, input int words, input bit gap);
    for (int k = 0; k < words; k++) begin
      if (gap && k[0]) begin
        mem_wready = 0; @(negedge clk);
        chk("R11 wvalid held on stall", mem_wvalid, 1);
      end
      mem_wready = 1;
      chk({tag, " word"}, mem_wdata, buf_model[8'(off + k)]);
      @(negedge clk);
    end
    mem_wready = 0;
    chk("R8 stream ends after last word", mem_wvalid, 0);
  endtask

  task automatic serve_read(input logic [7:0] off, input int words, input int bad_k, input bit gap);
    for (int k = 0; k < words; k++) begin
      if (gap && k[0]) begin mem_rvalid = 0; @(negedge clk); end
      mem_rvalid = 1;
      mem_rdata = buf_model[8'(off + k)] ^ ((k == bad_k) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    mem_rvalid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 no request after reset", mem_req, 0);
    host_rd(9'h000, d); chk("R1 reset status", d, 32'h2);
  endtask

  task automatic t_host_access;
    logic [31:0] d;
    for (int i = 0; i < 256; i++) begin
      buf_model[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5a, 8'hc3};
      host_wr({1'b1, i[7:0]}, buf_model[i]);
    end
    host_rd(9'h100, d);      chk("R2 buffer word 0", d, buf_model[0]);
    host_rd(9'h1ff, d);      chk("R2 buffer word 255", d, buf_model[255]);
    host_wr(9'h001, 32'h1234); host_rd(9'h001, d); chk("R2 address register", d, 32'h1234);
  endtask

  task automatic t_write_burst;
    logic [31:0] d;
    host_wr(9'h001, 32'h40);
    host_wr(9'h000, cmd(0, 0, 0, 8'd10, 8'd3));
    grant("R3", 32'h40, 8'd3, 1, 0);
    serve_write("R3", 8'd10, 4, 1);
    host_rd(9'h000, d); chk("R8 idle after write", d, 32'h2);
  endtask

  task automatic t_wrap;
    host_wr(9'h001, 32'h80);
    host_wr(9'h000, cmd(0, 0, 0, 8'd252, 8'd7));
    grant("R5", 32'h80, 8'd7, 1, 0);
    serve_write("R5 wrap", 8'd252, 8, 0);
  endtask

  task automatic t_read_pass;
    logic [31:0] d;
    host_wr(9'h001, 32'h40);
    host_wr(9'h000, cmd(1, 1, 0, 8'd20, 8'd5));
    grant("R4", 32'h40, 8'd5, 0, 0);
    serve_read(8'd20, 6, -1, 1);
    host_rd(9'h000, d); chk("R4 matching read keeps pass", d, 32'h2);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    host_wr(9'h000, cmd(1, 0, 0, 8'd30, 8'd3));
    grant("R4", 32'h40, 8'd3, 0, 0);
    serve_read(8'd30, 4, 2, 0);
    host_rd(9'h000, d); chk("R6 mismatch clears pass", d, 32'h0);
    host_wr(9'h000, cmd(1, 0, 0, 8'd30, 8'd3));
    grant("R6", 32'h40, 8'd3, 0, 0);
    serve_read(8'd30, 4, -1, 0);
    host_rd(9'h000, d); chk("R6 pass stays clear", d, 32'h0);
    host_wr(9'h000, cmd(0, 1, 0, 8'd0, 8'd0));
    grant("R7", 32'h40, 8'd0, 1, 0);
    serve_write("R7", 8'd0, 1, 0);
    host_rd(9'h000, d); chk("R7 check reset ignored on write", d, 32'h0);
    host_wr(9'h000, cmd(1, 1, 0, 8'd0, 8'd1));
    grant("R7", 32'h40, 8'd1, 0, 0);
    serve_read(8'd0, 2, -1, 0);
    host_rd(9'h000, d); chk("R7 check reset restores pass", d, 32'h2);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    host_wr(9'h000, cmd(0, 0, 0, 8'd5, 8'd2));
    host_rd(9'h000, d); chk("R8 busy during burst", d, 32'h3);
    host_wr(9'h000, cmd(1, 0, 1, 8'd9, 8'd9));
    grant("R8", 32'h40, 8'd2, 1, 0);
    serve_write("R8", 8'd5, 3, 0);
    repeat (3) @(negedge clk);
    chk("R8 command while busy ignored", mem_req, 0);
  endtask

  task automatic t_clamp;
    host_wr(9'h000, cmd(0, 0, 0, 8'd100, 8'h40));
    grant("R9", 32'h40, 8'd31, 1, 0);
    serve_write("R9 clamped", 8'd100, 32, 0);
    repeat (2) @(negedge clk);
    chk("R9 no extra beats", mem_req, 0);
  endtask

  task automatic t_dual;
    logic [31:0] d;
    host_wr(9'h000, cmd(1, 0, 1, 8'd7, 8'd0));
    grant("R10 read", 32'h40, 8'd0, 0, 1);
    serve_read(8'd7, 1, -1, 0);
    host_wr(9'h000, cmd(0, 0, 1, 8'd7, 8'd0));
    grant("R10 write", 32'h40, 8'd0, 1, 0);
    serve_write("R10", 8'd7, 1, 0);
    host_rd(9'h000, d); chk("R10 status after dual bursts", d, 32'h2);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_host_access;
    t_write_burst;
    t_wrap;
    t_read_pass;
    t_sticky;
    t_busy;
    t_clamp;
    t_dual;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule